// File: doc/BRIEF.md
# Optical Touch Frame Scan Sequencer

This block runs the scan of an optical touch frame. The frame has a ring of small boards on a shared backplane. Each board carries eight emitters and eight photodetectors. Every board has its own enable wire, so selecting a board needs no address decoding. A single role wire tells the enabled board what to do. When the role wire is low, the board lights the emitter named by the transmitter ID. When it is high, the board drives its eight detector outputs onto the shared data bus.

For each emitter, the sequencer does the following, in order:

1. It leaves every board deselected for one settle interval.
2. It enables the emitting board in transmit role for one settle interval.
3. It deselects everything again for one settle interval.
4. It enables the board on the far side of the ring in receive role for one settle interval.
5. It latches the data bus at the end of that interval.

The latched byte goes downstream under a valid/ready handshake. It travels with the board number, the emitter number and a hit flag that is set when any detector bit is set. The settle interval is a parameter. It is sized from the clock frequency to cover the roughly 2.1 us optical response of the frame.

The scan runs through emitters 0 to 7 on board 1, then board 2, and so on up to the last board. At the end of a frame it either starts over, if the run input is high, or returns to idle.

Top module: `tscan_top`

## Requirements
- R1: A synchronous active-high reset drives all board enables low, the role line low and the result valid low. The block then stays in that state while the run input is low.
- R2: At most one board enable is high in any cycle. Board k (numbered from 1) is driven on enable bit k-1.
- R3: Steps run in this order: transmitter 0 to 7 within board 1, then board 2, and so on up to board NUM_BOARDS. The result carries the board as a number from 1 to NUM_BOARDS and the transmitter as a 3-bit value.
- R4: Each step first holds all enables low for SETTLE_CYCLES cycles. It then drives the emitting board's enable high, with the role line low and the transmitter ID set to the step's emitter, for SETTLE_CYCLES cycles.
- R5: Next, all enables are low for another SETTLE_CYCLES cycles. Then the receiver board's enable is high with the role line high for SETTLE_CYCLES cycles. The receiver board is number ((b-1+NUM_BOARDS/2) mod NUM_BOARDS)+1 for emitting board b. The data bus (bit 7 the MSB) is captured on the clock edge that ends the last receive cycle.
- R6: The hit flag equals the OR of the 8 captured data bits.
- R7: The result becomes valid in the cycle after the capture. While valid is high and ready is low, the payload stays unchanged and all board enables stay low. The scan continues only after a cycle with both valid and ready high.
- R8: After the handshake of the final step of a frame, the scan wraps to board 1, transmitter 0 if the run input is high in that cycle. Otherwise it returns to idle. From idle, a high run input starts a new frame at board 1, transmitter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| runEn | input | 1 | Start / keep scanning |
| dataIn | input | 8 | Detector bits from the receiving board |
| boardEn | output | 14 | One-hot board enables, active high |
| txId | output | 3 | Emitter select on the enabled board |
| roleRecv | output | 1 | Low: transmit role; high: receive role |
| resValid | output | 1 | Result valid |
| resReady | input | 1 | Consumer ready |
| resBoard | output | 4 | Emitting board number, 1-based |
| resTx | output | 3 | Emitter number |
| resData | output | 8 | Captured detector bits |
| resHit | output | 1 | Any detector bit set |

## Verification
The bench builds the block with all 14 boards and a settle interval of 3 cycles. A full frame of 112 steps then fits into roughly fifteen hundred cycles. As a result, the end-of-frame wrap, the stop into idle and a later restart all occur within one short run. The opposite-board pairing is exercised for every board, including the wrap past the last index. A pseudo-random ready pattern produces stalls of varying length at every phase alignment. Pseudo-random data that is sometimes forced to zero covers both values of the hit flag.

// File: rtl/tscan_pkg.sv
package tscan_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GAP_EMIT,
    PH_EMIT,
    PH_GAP_RECV,
    PH_RECV,
    PH_OUT
  } scanPhase_e;

  typedef struct packed {
    logic capture;   // latch data bus at end of receive window
    logic advance;   // step to next emitter after handshake
    logic emitOn;    // emitting board enabled, transmit role
    logic recvOn;    // receiving board enabled, receive role
  } seqStrobe_t;

endpackage

// File: rtl/tscan_ctrl.sv
module tscan_ctrl
  import tscan_pkg::*;
#(
  parameter int SETTLE_CYCLES = 550
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       runEn,
  input  logic       resReady,
  input  logic       lastStep,
  output seqStrobe_t strobe,
  output logic       resValid
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  scanPhase_e phase;
  logic [CNT_W-1:0] settleCnt;
  logic cntDone;
  logic timedPhase;

  assign cntDone    = (settleCnt == CNT_LAST);
  assign timedPhase = (phase == PH_GAP_EMIT) || (phase == PH_EMIT) ||
                      (phase == PH_GAP_RECV) || (phase == PH_RECV);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      settleCnt <= '0;
    end else begin
      if (timedPhase) begin
        if (cntDone) settleCnt <= '0;
        else         settleCnt <= settleCnt + 1'b1;
      end
      case (phase)
        PH_IDLE:     if (runEn) phase <= PH_GAP_EMIT;
        PH_GAP_EMIT: if (cntDone) phase <= PH_EMIT;
        PH_EMIT:     if (cntDone) phase <= PH_GAP_RECV;
        PH_GAP_RECV: if (cntDone) phase <= PH_RECV;
        PH_RECV:     if (cntDone) phase <= PH_OUT;
        PH_OUT: begin
          if (resReady) begin
            if (lastStep && !runEn) phase <= PH_IDLE;
            else                    phase <= PH_GAP_EMIT;
          end
        end
        default:     phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture = (phase == PH_RECV) && cntDone;
    strobe.advance = (phase == PH_OUT) && resReady;
    strobe.emitOn  = (phase == PH_EMIT);
    strobe.recvOn  = (phase == PH_RECV);
  end

  assign resValid = (phase == PH_OUT);

endmodule

// File: rtl/tscan_datapath.sv
module tscan_datapath
  import tscan_pkg::*;
#(
  parameter int NUM_BOARDS   = 14,
  parameter int TX_PER_BOARD = 8,
  parameter int DATA_W       = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  seqStrobe_t            strobe,
  input  logic [DATA_W-1:0]     dataIn,
  output logic [NUM_BOARDS-1:0] boardEn,
  output logic [$clog2(TX_PER_BOARD)-1:0] txId,
  output logic                  roleRecv,
  output logic                  lastStep,
  output logic [$clog2(NUM_BOARDS+1)-1:0] resBoard,
  output logic [$clog2(TX_PER_BOARD)-1:0] resTx,
  output logic [DATA_W-1:0]     resData,
  output logic                  resHit
);

  localparam int IDX_W = $clog2(NUM_BOARDS);
  localparam int TX_W  = $clog2(TX_PER_BOARD);
  localparam int NUM_W = $clog2(NUM_BOARDS + 1);
  localparam int HALF  = NUM_BOARDS / 2;
  localparam logic [IDX_W-1:0] BOARD_LAST = IDX_W'(NUM_BOARDS - 1);
  localparam logic [TX_W-1:0]  TX_LAST    = TX_W'(TX_PER_BOARD - 1);

  logic [IDX_W-1:0] boardIdx;
  logic [TX_W-1:0]  txIdx;
  logic [IDX_W:0]   partnerSum;
  logic [IDX_W-1:0] partnerIdx;

  assign lastStep = (boardIdx == BOARD_LAST) && (txIdx == TX_LAST);

  // step counters: emitter inner, board outer
  always_ff @(posedge clk) begin
    if (rst) begin
      boardIdx <= '0;
      txIdx    <= '0;
    end else if (strobe.advance) begin
      if (txIdx == TX_LAST) begin
        txIdx <= '0;
        if (boardIdx == BOARD_LAST) boardIdx <= '0;
        else                        boardIdx <= boardIdx + 1'b1;
      end else begin
        txIdx <= txIdx + 1'b1;
      end
    end
  end

  // receiver sits across the ring from the emitter
  always_comb begin
    partnerSum = {1'b0, boardIdx} + (IDX_W + 1)'(HALF);
    if (partnerSum >= (IDX_W + 1)'(NUM_BOARDS))
      partnerSum = partnerSum - (IDX_W + 1)'(NUM_BOARDS);
    partnerIdx = partnerSum[IDX_W-1:0];
  end

  for (genvar k = 0; k < NUM_BOARDS; k++) begin : g_enable
    assign boardEn[k] = (strobe.emitOn && (boardIdx == IDX_W'(k))) ||
                        (strobe.recvOn && (partnerIdx == IDX_W'(k)));
  end

  assign txId     = txIdx;
  assign roleRecv = strobe.recvOn;

  always_ff @(posedge clk) begin
    if (rst) begin
      resBoard <= '0;
      resTx    <= '0;
      resData  <= '0;
      resHit   <= 1'b0;
    end else if (strobe.capture) begin
      resBoard <= NUM_W'(boardIdx) + 1'b1;
      resTx    <= txIdx;
      resData  <= dataIn;
      resHit   <= |dataIn;
    end
  end

endmodule

// File: rtl/tscan_top.sv
module tscan_top
  import tscan_pkg::*;
#(
  parameter int NUM_BOARDS    = 14,
  parameter int TX_PER_BOARD  = 8,
  parameter int DATA_W        = 8,
  parameter int CLK_MHZ       = 250,
  parameter int SETTLE_NS     = 2200,
  parameter int SETTLE_CYCLES = (SETTLE_NS * CLK_MHZ + 999) / 1000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  runEn,
  input  logic [DATA_W-1:0]     dataIn,
  output logic [NUM_BOARDS-1:0] boardEn,
  output logic [$clog2(TX_PER_BOARD)-1:0] txId,
  output logic                  roleRecv,
  output logic                  resValid,
  input  logic                  resReady,
  output logic [$clog2(NUM_BOARDS+1)-1:0] resBoard,
  output logic [$clog2(TX_PER_BOARD)-1:0] resTx,
  output logic [DATA_W-1:0]     resData,
  output logic                  resHit
);

  seqStrobe_t strobe;
  logic lastStep;

  tscan_ctrl #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .runEn    (runEn),
    .resReady (resReady),
    .lastStep (lastStep),
    .strobe   (strobe),
    .resValid (resValid)
  );

  tscan_datapath #(
    .NUM_BOARDS   (NUM_BOARDS),
    .TX_PER_BOARD (TX_PER_BOARD),
    .DATA_W       (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .boardEn  (boardEn),
    .txId     (txId),
    .roleRecv (roleRecv),
    .lastStep (lastStep),
    .resBoard (resBoard),
    .resTx    (resTx),
    .resData  (resData),
    .resHit   (resHit)
  );

endmodule

// File: rtl/tscan_checker.sv
module tscan_checker #(
  parameter int NUM_BOARDS   = 14,
  parameter int TX_PER_BOARD = 8,
  parameter int DATA_W       = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_BOARDS-1:0] boardEn,
  input logic                  roleRecv,
  input logic                  resValid,
  input logic                  resReady,
  input logic [$clog2(NUM_BOARDS+1)-1:0] resBoard,
  input logic [$clog2(TX_PER_BOARD)-1:0] resTx,
  input logic [DATA_W-1:0]     resData,
  input logic                  resHit
);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (boardEn == '0) && !roleRecv && !resValid);

  a_r2_one_board: assert property (@(posedge clk) disable iff (rst)
    $onehot0(boardEn));

  a_r5_recv_has_board: assert property (@(posedge clk) disable iff (rst)
    roleRecv |-> ($countones(boardEn) == 1));

  a_r6_hit_matches: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (resHit == (resData != '0)));

  a_r7_hold_payload: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resReady) |=> resValid && $stable(resData) &&
      $stable(resBoard) && $stable(resTx) && $stable(resHit));

  a_r7_stalled_quiet: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (boardEn == '0) && !roleRecv);

  a_r3_board_range: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (resBoard >= 1) && (resBoard <= NUM_BOARDS));

endmodule

bind tscan_top tscan_checker #(
  .NUM_BOARDS   (NUM_BOARDS),
  .TX_PER_BOARD (TX_PER_BOARD),
  .DATA_W       (DATA_W)
) u_tscan_checker (
  .clk      (clk),
  .rst      (rst),
  .boardEn  (boardEn),
  .roleRecv (roleRecv),
  .resValid (resValid),
  .resReady (resReady),
  .resBoard (resBoard),
  .resTx    (resTx),
  .resData  (resData),
  .resHit   (resHit)
);

// File: tb/test_tscan_top.sv
module test_tscan_top;

  localparam int NB = 14;
  localparam int NT = 8;
  localparam int S  = 3;
  localparam int FRAME = NB * NT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic runEn = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic resReady = 1'b0;
  logic [NB-1:0] boardEn;
  logic [2:0] txId;
  logic roleRecv, resValid, resHit;
  logic [3:0] resBoard;
  logic [2:0] resTx;
  logic [7:0] resData;

  always #2 clk = ~clk;  // 250 MHz

  tscan_top #(.NUM_BOARDS(NB), .TX_PER_BOARD(NT), .DATA_W(8),
              .SETTLE_CYCLES(S)) i_tscan_top (
    .clk(clk), .rst(rst), .runEn(runEn), .dataIn(dataIn),
    .boardEn(boardEn), .txId(txId), .roleRecv(roleRecv),
    .resValid(resValid), .resReady(resReady), .resBoard(resBoard),
    .resTx(resTx), .resData(resData), .resHit(resHit));

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  int hsCount = 0;
  int hitSeen = 0;
  int missSeen = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference model: phase 0 idle, 1 gap, 2 emit, 3 gap, 4 recv, 5 out
  int mPhase = 0, mCnt = 0, mBoard = 0, mTx = 0;
  int qBoard[$], qTx[$], qData[$];

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mPhase = 0; mCnt = 0; mBoard = 0; mTx = 0;
      qBoard.delete(); qTx.delete(); qData.delete();
    end else begin
      case (mPhase)
        0: if (runEn) begin mPhase = 1; mCnt = 0; end
        1, 2, 3, 4: begin
          if (mCnt == S - 1) begin
            mCnt = 0;
            if (mPhase == 4) begin
              qBoard.push_back(mBoard + 1);
              qTx.push_back(mTx);
              qData.push_back(int'(dataIn));
            end
            mPhase = mPhase + 1;
          end else mCnt = mCnt + 1;
        end
        default: if (resReady) begin
          void'(qBoard.pop_front()); void'(qTx.pop_front()); void'(qData.pop_front());
          hsCount++;
          if (mBoard == NB - 1 && mTx == NT - 1) begin
            mBoard = 0; mTx = 0;
            mPhase = runEn ? 1 : 0;
          end else begin
            if (mTx == NT - 1) begin mTx = 0; mBoard = mBoard + 1; end
            else mTx = mTx + 1;
            mPhase = 1;
          end
        end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int partnerOf(input int b);
    return (b + NB / 2) % NB;
  endfunction

  // drive inputs, then compare outputs against the model
  always @(negedge clk) begin
    logic [NB-1:0] expEn;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dataIn   = (lfsr[2:0] == 3'b000) ? 8'h00 : lfsr[15:8];
    resReady = (lfsr[5:4] != 2'b00);
    if (cyc > 0) begin
      expEn = '0;
      if (mPhase == 2) expEn[mBoard] = 1'b1;                 // R4 emitter window
      if (mPhase == 4) expEn[partnerOf(mBoard)] = 1'b1;      // R5 receiver window
      check(boardEn == expEn, "R2/R4/R5", "boardEn", int'(boardEn), int'(expEn));
      check(roleRecv == (mPhase == 4), "R5", "roleRecv", int'(roleRecv), int'(mPhase == 4));
      check(int'(txId) == mTx, "R3/R4", "txId", int'(txId), mTx);
      check(resValid == (mPhase == 5), "R7", "resValid", int'(resValid), int'(mPhase == 5));
      if (mPhase == 5 && resValid && qBoard.size() > 0) begin
        check(int'(resBoard) == qBoard[0], "R3", "resBoard", int'(resBoard), qBoard[0]);
        check(int'(resTx) == qTx[0], "R3", "resTx", int'(resTx), qTx[0]);
        check(int'(resData) == qData[0], "R5", "resData", int'(resData), qData[0]);
        check(resHit == (qData[0] != 0), "R6", "resHit", int'(resHit), int'(qData[0] != 0));
        if (resHit) hitSeen++; else missSeen++;
        if (resReady && hsCount == FRAME)
          check(resBoard == 4'd1 && resTx == 3'd0, "R8", "wrap step",
                int'(resBoard) * 8 + int'(resTx), 8);
      end
    end
  end

  task automatic finishRun;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet right after reset
    check(boardEn == '0 && !roleRecv && !resValid, "R1", "after reset",
          int'(boardEn) + int'(resValid), 0);
    repeat (10) @(negedge clk);
    check(boardEn == '0 && !resValid, "R1", "idle with run low",
          int'(boardEn) + int'(resValid), 0);
    // R8: start from idle, run through more than one frame
    runEn = 1'b1;
    while (hsCount < FRAME + 20) @(negedge clk);
    runEn = 1'b0;
    while (!(hsCount >= 2 * FRAME && mPhase == 0)) @(negedge clk);
    repeat (20) @(negedge clk);
    check(hsCount == 2 * FRAME, "R8", "steps before stop", hsCount, 2 * FRAME);
    check(boardEn == '0 && !resValid, "R8", "idle after stop",
          int'(boardEn) + int'(resValid), 0);
    check(hitSeen > 0, "R6", "hit samples seen", hitSeen, 1);
    check(missSeen > 0, "R6", "empty samples seen", missSeen, 1);
    // R8: restart from idle begins at board 1, emitter 0
    runEn = 1'b1;
    repeat (S + 2) @(negedge clk);
    check(boardEn == {{(NB-1){1'b0}}, 1'b1} && txId == 3'd0, "R8", "restart board",
          int'(boardEn), 1);
    runEn = 1'b0;
    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule